// File: doc/BRIEF.md
# Tone-pair steering validator

This block sits behind a dual-tone detector and decides when a detected tone pair counts as a key press. The detector supplies an early-steering level, high while two valid tones are present, and the 4-bit code of the pair. The block counts clock cycles to confirm that the level stays high long enough. When it does, the block registers the code into a latch and raises a guard output. After a programmable settle delay it raises a key flag. The key is released only after the level stays low for a separate, programmable absence time. Short bursts are therefore rejected and short dropouts are bridged.

Counting starts from the first sampled edge, so the whole recognition time is the detector's own delay plus the presence count. The whole inter-digit time is the detector's release delay plus the absence count. The latched code reaches the output bus only while the output enable is high. Otherwise the bus reads all zeros.

Top module: `tone_steer_gate`

## Requirements
- R1: A tone pair is registered only when est_in is sampled high on Pe consecutive rising edges, where Pe is pres_len and a value of 0 counts as 1. Registration takes effect at the Pe-th edge. A low sample before that restarts the count from zero, and a shorter burst leaves the latch and guard_out unchanged.
- R2: At the registration edge, code_in is captured into the latch. Later changes of code_in have no effect on the latch until the key has been released and a new pair is registered.
- R3: guard_out goes high at the registration edge. While the key is registered, it is updated to the sampled est_in on every edge. It is low whenever no key is registered.
- R4: key_flag rises at the Se-th edge after the registration edge, where Se is settle_len and a value of 0 counts as 1. It does not rise if the key is released at or before that edge.
- R5: A registered key is released when est_in is sampled low on Ae consecutive edges, where Ae is abs_len and a value of 0 counts as 1. At the Ae-th such edge, key_flag and guard_out clear and presence counting starts again.
- R6: A low run of est_in shorter than Ae edges is ignored. key_flag and the latched code are held, and the absence count restarts at the next high sample.
- R7: code_out equals the latch while oe is 1 and is 4'b0000 while oe is 0.
- R8: A synchronous active-high rst clears the latch, guard_out and key_flag at the next edge and returns the block to presence counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_in | input | 1 | Early-steering level from the tone detector |
| code_in | input | 4 | Decoded code of the current tone pair |
| pres_len | input | 16 | Presence guard count in cycles (0 counts as 1) |
| abs_len | input | 16 | Absence guard count in cycles (0 counts as 1) |
| settle_len | input | 16 | Settle delay from registration to key flag (0 counts as 1) |
| oe | input | 1 | Output enable for the code bus |
| code_out | output | 4 | Latched code when enabled, zero otherwise |
| guard_out | output | 1 | Guard-time output |
| key_flag | output | 1 | Delayed steering flag: a registered key is valid |

## Verification
Edges are counted from the first edge that samples est_in high. The latch and guard_out are due at edge Pe. key_flag is due at edge Pe+Se. The release is due at the Ae-th low edge after the burst, which is edge H+Ae for a burst of H edges. code_out follows oe in the same cycle. The bench changes inputs 1 ns after a rising edge and samples 1 ns after the next one, so every sample shows the state left by exactly one more edge. It records the edge index at which key_flag first rises and the index at which it falls. It also records how many edges guard_out is high and the code seen after the last high edge. These figures are compared with values worked out by hand from the counts above, including bursts one edge short, zero counts, and a release that comes before the settle delay ends.

// File: rtl/tone_steer_gate.sv
module tone_steer_gate #(
  parameter int CW = 4,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          est_in,
  input  logic [CW-1:0] code_in,
  input  logic [TW-1:0] pres_len,
  input  logic [TW-1:0] abs_len,
  input  logic [TW-1:0] settle_len,
  input  logic          oe,
  output logic [CW-1:0] code_out,
  output logic          guard_out,
  output logic          key_flag
);

  logic          reg_q, settling_q, guard_q, flag_q;
  logic [CW-1:0] latch_q;
  logic [TW-1:0] pcnt_q, acnt_q, scnt_q;
  logic [TW-1:0] pe, ae, se;
  logic          pres_done, abs_done, settle_done;

  assign pe = (pres_len   == '0) ? TW'(1) : pres_len;
  assign ae = (abs_len    == '0) ? TW'(1) : abs_len;
  assign se = (settle_len == '0) ? TW'(1) : settle_len;

  assign pres_done   = ({1'b0, pcnt_q} + 1'b1) >= {1'b0, pe};
  assign abs_done    = ({1'b0, acnt_q} + 1'b1) >= {1'b0, ae};
  assign settle_done = ({1'b0, scnt_q} + 1'b1) >= {1'b0, se};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q      <= 1'b0;
      settling_q <= 1'b0;
      guard_q    <= 1'b0;
      flag_q     <= 1'b0;
      latch_q    <= '0;
      pcnt_q     <= '0;
      acnt_q     <= '0;
      scnt_q     <= '0;
    end else if (!reg_q) begin
      if (est_in) begin
        if (pres_done) begin
          reg_q      <= 1'b1;
          settling_q <= 1'b1;
          guard_q    <= 1'b1;
          latch_q    <= code_in;
          pcnt_q     <= '0;
          acnt_q     <= '0;
          scnt_q     <= '0;
        end else begin
          pcnt_q <= pcnt_q + 1'b1;
        end
      end else begin
        pcnt_q <= '0;
      end
    end else begin
      guard_q <= est_in;
      if (settling_q) begin
        if (settle_done) begin
          flag_q     <= 1'b1;
          settling_q <= 1'b0;
        end else begin
          scnt_q <= scnt_q + 1'b1;
        end
      end
      if (!est_in) begin
        if (abs_done) begin
          reg_q      <= 1'b0;
          settling_q <= 1'b0;
          guard_q    <= 1'b0;
          flag_q     <= 1'b0;
          acnt_q     <= '0;
          pcnt_q     <= '0;
        end else begin
          acnt_q <= acnt_q + 1'b1;
        end
      end else begin
        acnt_q <= '0;
      end
    end
  end

  assign code_out  = oe ? latch_q : '0;
  assign guard_out = guard_q;
  assign key_flag  = flag_q;

  p_reg_needs_tone_r1: assert property (@(posedge clk) disable iff (rst)
    ($rose(reg_q) && !$past(rst)) |-> $past(est_in));

  p_latch_only_at_reg_r2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(latch_q) && !$past(rst)) |-> $rose(reg_q));

  p_guard_tracks_tone_r3: assert property (@(posedge clk) disable iff (rst)
    (guard_out && !$past(rst)) |-> $past(est_in));

  p_flag_after_latch_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(key_flag) && !$past(rst)) |-> (reg_q && $stable(latch_q)));

  p_flag_drop_on_gap_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(key_flag) && !$past(rst)) |-> (!$past(est_in) && !guard_out));

  p_hold_on_tone_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(key_flag) && $past(est_in) && !$past(rst)) |-> key_flag);

endmodule

// File: tb/tone_steer_gate_bench.sv
module tone_steer_gate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        est_in = 1'b0;
  logic [3:0]  code_in = 4'h0;
  logic [15:0] pres_len = 16'd1, abs_len = 16'd1, settle_len = 16'd1;
  logic        oe = 1'b1;
  logic [3:0]  code_out;
  logic        guard_out, key_flag;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tone_steer_gate u_tone_steer_gate (
    .clk(clk), .rst(rst), .est_in(est_in), .code_in(code_in),
    .pres_len(pres_len), .abs_len(abs_len), .settle_len(settle_len),
    .oe(oe), .code_out(code_out), .guard_out(guard_out), .key_flag(key_flag)
  );

  // P, S, A, H (burst edges), code, exp rise edge, exp fall edge, exp guard edges, exp code
  localparam int NV = 7;
  localparam int VEC [NV][9] = '{
    '{4, 2, 3, 10, 5,   6, 13,  7, 5},
    '{4, 2, 3,  3, 9,   0,  0,  0, 0},
    '{0, 0, 0,  2, 10,  2,  3,  2, 10},
    '{1, 5, 2,  3, 3,   0,  0,  3, 3},
    '{6, 1, 8,  6, 15,  7, 14,  1, 15},
    '{6, 1, 8,  5, 7,   0,  0,  0, 0},
    '{2, 3, 4, 20, 12,  5, 24, 19, 12}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; est_in = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic drive(input bit e, input int n);
    for (int k = 0; k < n; k++) begin
      est_in = e; tick();
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check(key_flag == 0 && guard_out == 0, "R8 reset outputs", {guard_out, key_flag}, 0);
    check(code_out == 0, "R8 reset latch", code_out, 0);

    for (int v = 0; v < NV; v++) begin
      int ae, rise, fall, gcnt, cseen;
      do_reset();
      check(code_out == 0 && key_flag == 0, "R8 reset between vectors", code_out, 0);
      pres_len = 16'(VEC[v][0]); settle_len = 16'(VEC[v][1]); abs_len = 16'(VEC[v][2]);
      code_in = 4'(VEC[v][4]); oe = 1'b1;
      ae = (VEC[v][2] == 0) ? 1 : VEC[v][2];
      rise = 0; fall = 0; gcnt = 0; cseen = 0;
      for (int i = 1; i <= VEC[v][3] + ae + 4; i++) begin
        est_in = (i <= VEC[v][3]);
        tick();
        if (key_flag && rise == 0) rise = i;
        if (!key_flag && rise != 0 && fall == 0) fall = i;
        if (guard_out) gcnt++;
        if (i == VEC[v][3]) cseen = code_out;
      end
      check(rise == VEC[v][5], "R1 R4 R8 flag rise edge", rise, VEC[v][5]);
      check(fall == VEC[v][6], "R5 flag fall edge", fall, VEC[v][6]);
      check(gcnt == VEC[v][7], "R3 guard edges", gcnt, VEC[v][7]);
      check(cseen == VEC[v][8], "R2 latched code", cseen, VEC[v][8]);
    end

    // R1: a low sample restarts the presence count
    do_reset();
    pres_len = 16'd4; settle_len = 16'd1; abs_len = 16'd4; code_in = 4'h8;
    drive(1, 3); drive(0, 1); drive(1, 3);
    check(guard_out == 0 && code_out == 0, "R1 interrupted burst rejected", code_out, 0);
    drive(1, 1);
    check(guard_out == 1 && code_out == 4'h8, "R1 registers at fourth consecutive edge", code_out, 8);

    // R6: dropout bridged, code held; R3: guard re-rises
    do_reset();
    pres_len = 16'd2; settle_len = 16'd1; abs_len = 16'd4; code_in = 4'h6;
    drive(1, 6);
    check(key_flag == 1 && code_out == 4'h6, "R4 flag up before dropout", key_flag, 1);
    code_in = 4'h9;
    drive(0, 3);
    check(key_flag == 1 && guard_out == 0, "R6 short dropout held", key_flag, 1);
    check(code_out == 4'h6, "R6 code held during dropout", code_out, 6);
    drive(1, 3);
    check(guard_out == 1 && code_out == 4'h6, "R3 guard returns, R2 no relatch", code_out, 6);
    drive(0, 3);
    check(key_flag == 1, "R6 absence count restarted", key_flag, 1);
    drive(0, 1);
    check(key_flag == 0 && guard_out == 0, "R5 release at fourth low edge", key_flag, 0);
    drive(1, 2);
    check(code_out == 4'h9, "R2 new key latched after release", code_out, 9);

    // R7: output enable gating
    oe = 1'b0; #1;
    check(code_out == 4'h0, "R7 bus zero when disabled", code_out, 0);
    oe = 1'b1; #1;
    check(code_out == 4'h9, "R7 bus shows latch when enabled", code_out, 9);

    // R8: reset while a key is held
    drive(1, 2);
    check(key_flag == 1, "R4 flag up before reset", key_flag, 1);
    rst = 1'b1; tick(); rst = 1'b0;
    check(key_flag == 0 && guard_out == 0 && code_out == 0, "R8 reset mid-key", code_out, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule